// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block owns the enable pin of an external power-management device. Once software arms it, an event from the second alarm channel of the clock core switches the power-enable output off, and the output stays off until one of up to four external wake inputs reaches its programmed active level. Each wake input has its own enable bit and its own polarity bit. The inputs pass through a synchroniser before they are qualified, so they may come from any asynchronous source.

Next to the power sequencing, the block keeps a sticky flag for the second alarm channel. Software clears the flag by writing a one to it. The flag can raise an interrupt line when its enable bit is set. A small register port gives access to three words: the power control word (address 0), the status word (address 1) and the interrupt-enable word (address 2). Address 3 reads as zero. A read returns the word selected by the address combinationally. A write takes effect at the rising clock edge where `reg_wr_i` is high.

Top module: `pmic_wake_ctrl`

## Requirements
- R1: After reset the power-enable output is high, every wake enable bit is 0, every polarity bit is 1 (the control word reads 0x000000F0), the alarm flag is 0, the interrupt enable is 0 and the interrupt output is low.
- R2: In the control word, bit 16 arms power control, bits 0..3 enable wake inputs 0..3 and bits 4..7 hold the polarity of wake inputs 0..3 (1 = active-low, 0 = active-high). All other bits read as 0, so writing 0xFFFFFFFF reads back 0x000100FF.
- R3: While bit 16 is clear, the output is high whatever the alarm and wake inputs do. A write that clears bit 16 makes the output high from the edge of that write.
- R4: With bit 16 set and the output high, an alarm event sampled at a rising edge drives the output low right after that edge.
- R5: While the output is low, an enabled wake input held at its active level raises the output after the third rising edge that follows the pin change. Two edges pass through the synchroniser and one passes through the state register. After the second edge the output is still low.
- R6: A wake input whose enable bit is clear, or an enabled input at its inactive level, leaves the output low. A further alarm event while the output is low keeps it low.
- R7: The alarm flag (status word bit 7) is set at the edge where an alarm event is sampled, whether or not power control is armed.
- R8: Writing the status word with bit 7 = 1 clears the flag, and writing it with bit 7 = 0 has no effect. If an alarm event and a clear fall in the same cycle, the flag stays set.
- R9: The interrupt enable is bit 4 of the word at address 2. The interrupt output is high exactly while both the flag and that enable are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm2_evt_i | input | 1 | One-cycle match event from the second alarm channel |
| wake_pin_i | input | NUM_WAKE | Asynchronous external wake inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select: 0 control, 1 status, 2 interrupt enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| pwr_en_o | output | 1 | Power-enable output, high = power on |
| alarm2_irq_o | output | 1 | Alarm interrupt request |

## Verification
Each result has a fixed due cycle:
- A register write shows on the read port and on `pwr_en_o` right after its own edge.
- An alarm event moves the flag and the output at the edge that samples it.
- A wake edge reaches the output only at the third rising edge.

The bench changes every input on a falling edge and reads the outputs on the next falling edge, after the exact number of rising edges counted above. For the wake path it also checks the output after the second edge, to prove the latency is not shorter. The sweep covers every wake input with both polarities, enabled and disabled. In each case the other inputs are driven to their active levels, so a wrong mask or polarity shows up.

// File: rtl/pmic_wake_pkg.sv
package pmic_wake_pkg;
   localparam int DATA_W        = 32;
   localparam int ADDR_W        = 2;
   localparam int MAX_WAKE      = 4;

   localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;

   localparam int CTRL_EN_LSB   = 0;
   localparam int CTRL_POL_LSB  = 4;
   localparam int CTRL_ARM_BIT  = 16;
   localparam int STAT_FLAG_BIT = 7;
   localparam int IEN_BIT       = 4;

   typedef enum logic {
      PWR_ON  = 1'b0,
      PWR_OFF = 1'b1
   } pwr_state_e;
endpackage

// File: rtl/pmic_wake_sync.sv
module pmic_wake_sync #(
   parameter int NUM_WAKE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] pin_i,
   input  logic [NUM_WAKE-1:0] en_i,
   input  logic [NUM_WAKE-1:0] pol_i,
   output logic                hit_o
);
   logic [NUM_WAKE-1:0] active;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pmic_wake_sync: SYNC_STAGES must be at least 2");
   end

   for (genvar p = 0; p < NUM_WAKE; p++) begin : g_pin
      logic [SYNC_STAGES-1:0] shift_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shift_q <= '0;
         end else begin
            shift_q <= {shift_q[SYNC_STAGES-2:0], pin_i[p]};
         end
      end

      // polarity bit 1 means the pin is active when low
      assign active[p] = en_i[p] & (shift_q[SYNC_STAGES-1] ^ pol_i[p]);
   end

   assign hit_o = |active;
endmodule

// File: rtl/pmic_pwr_fsm.sv
module pmic_pwr_fsm
   import pmic_wake_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic alarm_i,
   input  logic wake_hit_i,
   output logic pwr_en_o
);
   pwr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!arm_i) begin
         state_d = PWR_ON;
      end else begin
         unique case (state_q)
            PWR_ON:  if (alarm_i)    state_d = PWR_OFF;
            PWR_OFF: if (wake_hit_i) state_d = PWR_ON;
            default: state_d = PWR_ON;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWR_ON;
      end else begin
         state_q <= state_d;
      end
   end

   // disarming forces power on without waiting for the state register
   assign pwr_en_o = (state_q == PWR_ON) | ~arm_i;
endmodule

// File: rtl/pmic_alarm_status.sv
module pmic_alarm_status (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_i,
   input  logic clr_i,
   input  logic ien_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (alarm_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & ien_i;
endmodule

// File: rtl/pmic_wake_ctrl.sv
module pmic_wake_ctrl
   import pmic_wake_pkg::*;
#(
   parameter int NUM_WAKE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alarm2_evt_i,
   input  logic [NUM_WAKE-1:0] wake_pin_i,
   input  logic                reg_wr_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic                pwr_en_o,
   output logic                alarm2_irq_o
);
   localparam logic [DATA_W-1:0] WAKE_MASK = DATA_W'((1 << NUM_WAKE) - 1);
   localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'(1) << CTRL_ARM_BIT) | (WAKE_MASK << CTRL_POL_LSB) |
      (WAKE_MASK << CTRL_EN_LSB)   | (DATA_W'(1) << STAT_FLAG_BIT) |
      (DATA_W'(1) << IEN_BIT);

   if (NUM_WAKE < 1 || NUM_WAKE > MAX_WAKE) begin : g_bad_wake
      $error("pmic_wake_ctrl: NUM_WAKE must be 1..4");
   end

   logic                arm_q;
   logic [NUM_WAKE-1:0] wake_en_q;
   logic [NUM_WAKE-1:0] wake_pol_q;
   logic                ien_q;
   logic                wake_hit;
   logic                alarm_flag;
   logic                stat_clr;
   logic                wr_ctrl, wr_ien;
   logic                unused_wdata;

   assign wr_ctrl  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
   assign wr_ien   = reg_wr_i && (reg_addr_i == ADDR_IEN);
   assign stat_clr = reg_wr_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[STAT_FLAG_BIT];
   assign unused_wdata = ^(reg_wdata_i & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q      <= 1'b0;
         wake_en_q  <= '0;
         wake_pol_q <= '1;
      end else if (wr_ctrl) begin
         arm_q      <= reg_wdata_i[CTRL_ARM_BIT];
         wake_en_q  <= reg_wdata_i[CTRL_EN_LSB +: NUM_WAKE];
         wake_pol_q <= reg_wdata_i[CTRL_POL_LSB +: NUM_WAKE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= 1'b0;
      end else if (wr_ien) begin
         ien_q <= reg_wdata_i[IEN_BIT];
      end
   end

   pmic_wake_sync #(
      .NUM_WAKE    (NUM_WAKE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (wake_pin_i),
      .en_i  (wake_en_q),
      .pol_i (wake_pol_q),
      .hit_o (wake_hit)
   );

   pmic_pwr_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm_q),
      .alarm_i    (alarm2_evt_i),
      .wake_hit_i (wake_hit),
      .pwr_en_o   (pwr_en_o)
   );

   pmic_alarm_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .alarm_i (alarm2_evt_i),
      .clr_i   (stat_clr),
      .ien_i   (ien_q),
      .flag_o  (alarm_flag),
      .irq_o   (alarm2_irq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         ADDR_CTRL: begin
            reg_rdata_o[CTRL_ARM_BIT] = arm_q;
            for (int i = 0; i < NUM_WAKE; i++) begin
               reg_rdata_o[CTRL_EN_LSB + i]  = wake_en_q[i];
               reg_rdata_o[CTRL_POL_LSB + i] = wake_pol_q[i];
            end
         end
         ADDR_STAT: reg_rdata_o[STAT_FLAG_BIT] = alarm_flag;
         ADDR_IEN:  reg_rdata_o[IEN_BIT]       = ien_q;
         default:   reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/pmic_wake_ctrl_chk.sv
module pmic_wake_ctrl_chk
   import pmic_wake_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              alarm2_evt_i,
   input logic              reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic              pwr_en_o,
   input logic              alarm2_irq_o,
   input logic              arm_q,
   input logic              wake_hit,
   input logic              alarm_flag
);
   p_disarm_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_CTRL && !reg_wdata_i[CTRL_ARM_BIT]) |=> pwr_en_o);

   p_alarm_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && pwr_en_o && alarm2_evt_i && !(reg_wr_i && reg_addr_i == ADDR_CTRL))
      |=> !pwr_en_o);

   p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en_o) |-> $past(alarm2_evt_i));

   p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en_o) |-> ($past(wake_hit) || !arm_q));

   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm2_evt_i |=> alarm_flag);

   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_STAT && reg_wdata_i[STAT_FLAG_BIT] && !alarm2_evt_i)
      |=> !alarm_flag);

   p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_IEN && !reg_wdata_i[IEN_BIT]) |=> !alarm2_irq_o);
endmodule

bind pmic_wake_ctrl pmic_wake_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alarm2_evt_i (alarm2_evt_i),
   .reg_wr_i     (reg_wr_i),
   .reg_addr_i   (reg_addr_i),
   .reg_wdata_i  (reg_wdata_i),
   .pwr_en_o     (pwr_en_o),
   .alarm2_irq_o (alarm2_irq_o),
   .arm_q        (arm_q),
   .wake_hit     (wake_hit),
   .alarm_flag   (alarm_flag)
);

// File: tb/pmic_wake_ctrl_bench.sv
module pmic_wake_ctrl_bench;
   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alarm2_evt_i = 1'b0;
   logic [NW-1:0] wake_pin_i = '0;
   logic          reg_wr_i = 1'b0;
   logic [1:0]    reg_addr_i = 2'd0;
   logic [31:0]   reg_wdata_i = '0;
   logic [31:0]   reg_rdata_o;
   logic          pwr_en_o;
   logic          alarm2_irq_o;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pmic_wake_ctrl #(.NUM_WAKE(NW), .SYNC_STAGES(2)) u_pmic_wake_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .alarm2_evt_i (alarm2_evt_i),
      .wake_pin_i   (wake_pin_i),
      .reg_wr_i     (reg_wr_i),
      .reg_addr_i   (reg_addr_i),
      .reg_wdata_i  (reg_wdata_i),
      .reg_rdata_o  (reg_rdata_o),
      .pwr_en_o     (pwr_en_o),
      .alarm2_irq_o (alarm2_irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr_i = a;
      #1;
      d = reg_rdata_o;
   endtask

   task automatic alarm_pulse();
      @(negedge clk);
      alarm2_evt_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      alarm2_evt_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      wake_pin_i = '1;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      check("R1 pwr_en", {31'd0, pwr_en_o}, 32'd1);
      rd(2'd0, v); check("R1 ctrl word", v, 32'h0000_00F0);
      rd(2'd1, v); check("R1 status word", v, 32'h0);
      rd(2'd2, v); check("R1 irq enable", v, 32'h0);
      check("R1 irq", {31'd0, alarm2_irq_o}, 32'd0);

      // R2 register layout
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R2 ctrl mask", v, 32'h0001_00FF);
      wr(2'd0, 32'h0000_0000);
      rd(2'd0, v); check("R2 ctrl clear", v, 32'h0);
      rd(2'd3, v); check("R2 spare word", v, 32'h0);

      // R3 disarmed: alarm has no effect on output; R7 flag still set
      alarm_pulse();
      check("R3 disarmed alarm", {31'd0, pwr_en_o}, 32'd1);
      rd(2'd1, v); check("R7 flag set unarmed", v, 32'h80);

      // R9 interrupt gating
      check("R9 irq masked", {31'd0, alarm2_irq_o}, 32'd0);
      wr(2'd2, 32'h10);
      check("R9 irq raised", {31'd0, alarm2_irq_o}, 32'd1);
      rd(2'd2, v); check("R9 ien readback", v, 32'h10);

      // R8 write-one-to-clear
      wr(2'd1, 32'h0000_007F);
      rd(2'd1, v); check("R8 write zero keeps flag", v, 32'h80);
      wr(2'd1, 32'h80);
      rd(2'd1, v); check("R8 clear", v, 32'h0);
      check("R9 irq after clear", {31'd0, alarm2_irq_o}, 32'd0);

      // R8 set wins over clear in the same cycle
      @(negedge clk);
      alarm2_evt_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 32'h80;
      @(posedge clk);
      @(negedge clk);
      alarm2_evt_i = 1'b0; reg_wr_i = 1'b0;
      rd(2'd1, v); check("R8 set beats clear", v, 32'h80);
      check("R9 irq with flag", {31'd0, alarm2_irq_o}, 32'd1);
      wr(2'd2, 32'h0);
      check("R9 irq disabled", {31'd0, alarm2_irq_o}, 32'd0);
      wr(2'd1, 32'h80);

      // R6 alarm while off keeps off
      wake_pin_i = '1;
      wr(2'd0, 32'h0001_00F0);
      idle(3);
      alarm_pulse();
      check("R4 armed alarm off", {31'd0, pwr_en_o}, 32'd0);
      alarm_pulse();
      check("R6 second alarm stays off", {31'd0, pwr_en_o}, 32'd0);
      idle(4);
      check("R6 no wake stays off", {31'd0, pwr_en_o}, 32'd0);
      wr(2'd0, 32'h0);
      check("R3 disarm restores", {31'd0, pwr_en_o}, 32'd1);

      // sweep: pin x polarity x enable
      for (int pin = 0; pin < NW; pin++) begin
         for (int pol = 0; pol < 2; pol++) begin
            for (int en = 0; en < 2; en++) begin
               logic [NW-1:0] inact;
               logic [31:0]   cw;
               string         tag;
               inact = pol ? '1 : '0;
               cw = 32'h0001_0000 | (pol ? 32'hF0 : 32'h0) | (en ? (32'd1 << pin) : 32'h0);
               tag = $sformatf("pin%0d pol%0d en%0d", pin, pol, en);
               wake_pin_i = inact;
               wr(2'd0, cw);
               idle(4);
               check({"R4 before alarm ", tag}, {31'd0, pwr_en_o}, 32'd1);
               alarm_pulse();
               check({"R4 after alarm ", tag}, {31'd0, pwr_en_o}, 32'd0);
               // other pins active, only this pin may be enabled
               wake_pin_i = inact ^ ~(NW'(1) << pin);
               idle(4);
               check({"R6 other pins ignored ", tag}, {31'd0, pwr_en_o}, 32'd0);
               // this pin active
               wake_pin_i = inact ^ (NW'(1) << pin);
               @(posedge clk); @(posedge clk); @(negedge clk);
               check({"R5 latency two edges ", tag}, {31'd0, pwr_en_o}, 32'd0);
               @(posedge clk); @(negedge clk);
               check({"R5 R6 third edge ", tag}, {31'd0, pwr_en_o}, 32'(en));
               wr(2'd0, 32'h0);
               check({"R3 disarm ", tag}, {31'd0, pwr_en_o}, 32'd1);
               wr(2'd1, 32'h80);
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule